// File: doc/BRIEF.md
# Half-Rate to Full-Rate Word Retimer

This block carries a data word from a slow clock domain into a fast domain whose clock runs at exactly twice the slow frequency and is phase-related to it. The source presents a fresh word on every rising edge of the slow clock. The block does not clock its data flops from the slow clock. Instead it treats the slow clock as an ordinary input and samples it on the falling edge of the fast clock. That sample is retimed onto the fast rising edge, which gives a phase flag that lives fully in the fast domain.

The phase flag drives a capture enable. The wide data bus is therefore latched once per slow period, well inside the window where the word is stable. Because of this, every data bit gets a whole fast period of setup and hold margin. The only path with a half-period budget is the single falling-edge sampler. A parameter chooses which level of the phase flag starts a capture, so the sampling instant can be moved by one fast cycle. Each capture loads an output register and raises a one-cycle valid strobe.

Top module: `hrfr_retimer`

## Requirements
- R1: `phase_flag` equals the level of `slow_clk` sampled at the previous falling edge of `clk_fast`, presented after the next rising edge. Observed between edges, it equals the `slow_clk` level seen at the falling edge one fast cycle earlier.
- R2: A capture happens at a rising edge of `clk_fast` where the phase flag, just before that edge, equals `CAPTURE_POL`. With `CAPTURE_POL`=1 the capture follows a high flag; with `CAPTURE_POL`=0 it follows a low flag.
- R3: `dout` changes only at a capture. In every other cycle it holds the last captured word.
- R4: `dout_vld` is high for exactly one fast cycle per capture. In steady operation consecutive pulses are exactly two fast cycles apart.
- R5: Every word from the slow domain is captured exactly once and in order. No word is repeated and none is skipped.
- R6: While `rst` is high at a rising edge of `clk_fast`, `phase_flag`, `dout_vld` and `dout` all become zero at that edge.
- R7: `dout_vld` stays low for the first two rising edges after `rst` falls. The first capture comes at the third or fourth edge, depending on the slow-clock phase.
- R8: The captured word equals `din` as it stood at the capture edge, bit for bit, for any bit pattern over the full `DATA_W` width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast clock, twice the slow frequency |
| rst | input | 1 | Synchronous reset, active high |
| slow_clk | input | 1 | Slow clock, treated as a sampled signal |
| din | input | DATA_W | Word from the slow domain, new on each slow rising edge |
| dout | output | DATA_W | Last captured word |
| dout_vld | output | 1 | One-cycle strobe on each capture |
| phase_flag | output | 1 | Recovered slow-clock phase in the fast domain |

## Verification
Two instances run side by side from the same stimulus, one with each capture polarity. Any difference between them can then be traced to the sampling instant and not to the data path. Four word patterns are used. A counting sequence exposes skipped or repeated words. A walking one exposes swapped or stuck bits. Alternating all-ones and all-zeros words make a repeated capture impossible to confuse with a new word, since the bench tracks words by index and not by value. An XOR pattern covers mixed bit values. A reset issued in the middle of a run shows that the registers clear, that the warm-up blanking holds, and that capture resumes on the correct cadence.

// File: rtl/hrfr_pkg.sv
package hrfr_pkg;

   // Fast cycles after reset before the phase pipeline holds genuine samples.
   localparam int unsigned HRFR_WARM_CYCLES = 2;

   typedef enum logic {
      CAP_ON_LOW  = 1'b0,
      CAP_ON_HIGH = 1'b1
   } cap_pol_e;

endpackage

// File: rtl/hrfr_phase_track.sv
// Recovers the slow-clock phase: falling-edge sample, then rising-edge retime.
module hrfr_phase_track (
   input  logic clk,
   input  logic rst,
   input  logic slow_in,
   output logic phase_q
);

   logic neg_q;

   // The only half-period path in the block: slow_in -> neg_q -> phase_q.
   always_ff @(negedge clk) begin
      if (rst) neg_q <= 1'b0;
      else     neg_q <= slow_in;
   end

   always_ff @(posedge clk) begin
      if (rst) phase_q <= 1'b0;
      else     phase_q <= neg_q;
   end

endmodule

// File: rtl/hrfr_cap_ctrl.sv
// Turns the phase flag into a capture enable, with warm-up blanking after reset.
module hrfr_cap_ctrl #(
   parameter int CAPTURE_POL = 1,
   parameter int WARM        = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic phase_q,
   output logic cap_en,
   output logic vld_q
);
   import hrfr_pkg::*;

   localparam int CW = (WARM < 1) ? 1 : $clog2(WARM + 1);

   logic [CW-1:0] warm_cnt;
   logic          warm_done;
   logic          phase_hit;

   generate
      if (CAPTURE_POL == int'(CAP_ON_HIGH)) begin : g_pol_high
         assign phase_hit = phase_q;
      end else begin : g_pol_low
         assign phase_hit = ~phase_q;
      end
   endgenerate

   assign warm_done = (warm_cnt == CW'(WARM));
   assign cap_en    = phase_hit & warm_done;

   always_ff @(posedge clk) begin
      if (rst)             warm_cnt <= '0;
      else if (!warm_done) warm_cnt <= warm_cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= cap_en;
   end

endmodule

// File: rtl/hrfr_word_reg.sv
// Wide capture register; its inputs see a full fast period thanks to cap_en.
module hrfr_word_reg #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] q_out
);

   always_ff @(posedge clk) begin
      if (rst)         q_out <= '0;
      else if (cap_en) q_out <= d_in;
   end

endmodule

// File: rtl/hrfr_retimer.sv
module hrfr_retimer #(
   parameter int DATA_W      = 16,
   parameter int CAPTURE_POL = 1
) (
   input  logic              clk_fast,
   input  logic              rst,
   input  logic              slow_clk,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_vld,
   output logic              phase_flag
);
   import hrfr_pkg::*;

   localparam int WARM = int'(HRFR_WARM_CYCLES);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("hrfr_retimer: DATA_W must be at least 1");
      end
      if (CAPTURE_POL != 0 && CAPTURE_POL != 1) begin : g_bad_pol
         $error("hrfr_retimer: CAPTURE_POL must be 0 or 1");
      end
   endgenerate

   logic cap_en;

   hrfr_phase_track u_phase (
      .clk     (clk_fast),
      .rst     (rst),
      .slow_in (slow_clk),
      .phase_q (phase_flag)
   );

   hrfr_cap_ctrl #(
      .CAPTURE_POL (CAPTURE_POL),
      .WARM        (WARM)
   ) u_ctrl (
      .clk     (clk_fast),
      .rst     (rst),
      .phase_q (phase_flag),
      .cap_en  (cap_en),
      .vld_q   (dout_vld)
   );

   hrfr_word_reg #(
      .DATA_W (DATA_W)
   ) u_word (
      .clk    (clk_fast),
      .rst    (rst),
      .cap_en (cap_en),
      .d_in   (din),
      .q_out  (dout)
   );

endmodule

// File: rtl/hrfr_retimer_chk.sv
// Property checker bound to the retimer. Assumes a running slow clock.
module hrfr_retimer_chk #(
   parameter int DATA_W      = 16,
   parameter int CAPTURE_POL = 1
) (
   input logic              clk_fast,
   input logic              rst,
   input logic              phase_flag,
   input logic [DATA_W-1:0] dout,
   input logic              dout_vld
);

   // Fast edges since reset release, saturating at 5.
   logic [2:0] cyc;
   always_ff @(posedge clk_fast) begin
      if (rst)           cyc <= '0;
      else if (cyc != 3'd5) cyc <= cyc + 3'd1;
   end

   p_phase_toggle_r1: assert property (@(posedge clk_fast) disable iff (rst)
      (cyc == 3'd5) |-> (phase_flag != $past(phase_flag)));

   p_vld_pol_r2: assert property (@(posedge clk_fast) disable iff (rst)
      dout_vld |-> ($past(phase_flag) == 1'(CAPTURE_POL)));

   p_hold_r3: assert property (@(posedge clk_fast) disable iff (rst)
      !dout_vld |-> $stable(dout));

   p_single_pulse_r4: assert property (@(posedge clk_fast) disable iff (rst)
      dout_vld |=> !dout_vld);

   p_no_miss_r5: assert property (@(posedge clk_fast) disable iff (rst)
      (cyc == 3'd5) |-> (dout_vld || $past(dout_vld)));

   p_reset_clear_r6: assert property (@(posedge clk_fast)
      rst |=> (!dout_vld && !phase_flag && dout == '0));

   p_warm_blank_r7: assert property (@(posedge clk_fast) disable iff (rst)
      (cyc <= 3'd2) |-> !dout_vld);

endmodule

bind hrfr_retimer hrfr_retimer_chk #(
   .DATA_W      (DATA_W),
   .CAPTURE_POL (CAPTURE_POL)
) chk_i (
   .clk_fast   (clk_fast),
   .rst        (rst),
   .phase_flag (phase_flag),
   .dout       (dout),
   .dout_vld   (dout_vld)
);

// File: tb/hrfr_retimer_tb_top.sv
module hrfr_retimer_tb_top;
   localparam int W = 12;

   logic         clk  = 1'b0;
   logic         rst  = 1'b1;
   logic         slow = 1'b0;
   logic [W-1:0] din  = '0;
   int           cur_idx = 0;
   int           mode = 0;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;   // 250 MHz

   logic [W-1:0] dout_a, dout_b;
   logic         vld_a, vld_b, ph_a, ph_b;

   hrfr_retimer #(.DATA_W(W), .CAPTURE_POL(1)) dut_i (
      .clk_fast(clk), .rst(rst), .slow_clk(slow), .din(din),
      .dout(dout_a), .dout_vld(vld_a), .phase_flag(ph_a));

   hrfr_retimer #(.DATA_W(W), .CAPTURE_POL(0)) dut_n_i (
      .clk_fast(clk), .rst(rst), .slow_clk(slow), .din(din),
      .dout(dout_b), .dout_vld(vld_b), .phase_flag(ph_b));

   logic [W-1:0] o_d [2];
   logic         o_v [2];
   logic         o_p [2];
   assign o_d[0] = dout_a; assign o_v[0] = vld_a; assign o_p[0] = ph_a;
   assign o_d[1] = dout_b; assign o_v[1] = vld_b; assign o_p[1] = ph_b;

   function automatic logic [W-1:0] word_of(input int m, input int idx);
      case (m)
         0:       return W'(idx * 37 + 5);
         1:       return W'(1) << (idx % W);
         2:       return (idx % 2 != 0) ? '1 : '0;
         default: return W'(12'hA5A) ^ W'(idx);
      endcase
   endfunction

   // Slow-domain source: slow clock and words change 1 ns after a fast rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (!slow) begin
            slow = 1'b1;
            cur_idx++;
            din = word_of(mode, cur_idx);
         end else begin
            slow = 1'b0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // Observation state, sampled at falling edges.
   int           k = 0;
   logic [W-1:0] din_prev = '0;
   int           idx_prev = 0;
   logic         slow_prev = 1'b0;
   int           last_idx [2] = '{-1, -1};
   int           gap [2] = '{0, 0};
   int           caps [2] = '{0, 0};
   logic [W-1:0] dprev [2] = '{'0, '0};
   logic         pprev [2] = '{1'b0, 1'b0};

   task automatic check_cycle();
      @(negedge clk);
      if (rst) begin
         k = 0;
         for (int d = 0; d < 2; d++) begin
            chk(!o_v[d], "R6 vld cleared", o_v[d], 0);
            chk(o_d[d] == '0, "R6 dout cleared", o_d[d], 0);
            chk(!o_p[d], "R6 phase cleared", o_p[d], 0);
            last_idx[d] = -1;
            gap[d] = 0;
         end
      end else begin
         k++;
         for (int d = 0; d < 2; d++) begin
            if (k <= 2) chk(!o_v[d], "R7 warm-up blanking", o_v[d], 0);
            if (k >= 2) chk(o_p[d] == slow_prev, "R1 phase flag", o_p[d], slow_prev);
            if (k >= 3) begin
               gap[d]++;
               if (o_v[d]) begin
                  caps[d]++;
                  chk(o_d[d] == din_prev, "R8 captured word", o_d[d], din_prev);
                  chk(pprev[d] == ((d == 0) ? 1'b1 : 1'b0), "R2 capture polarity",
                      pprev[d], (d == 0) ? 1 : 0);
                  if (last_idx[d] >= 0) begin
                     chk(idx_prev == last_idx[d] + 1, "R5 word order", idx_prev, last_idx[d] + 1);
                     chk(gap[d] == 2, "R4 pulse spacing", gap[d], 2);
                  end else begin
                     chk(k == 3 || k == 4, "R7 first capture edge", k, 3);
                  end
                  last_idx[d] = idx_prev;
                  gap[d] = 0;
               end else begin
                  chk(o_d[d] == dprev[d], "R3 dout hold", o_d[d], dprev[d]);
                  if (last_idx[d] >= 0) chk(gap[d] < 2, "R5 missed word", gap[d], 1);
               end
            end
         end
      end
      din_prev  = din;
      idx_prev  = cur_idx;
      slow_prev = slow;
      for (int d = 0; d < 2; d++) begin
         dprev[d] = o_d[d];
         pprev[d] = o_p[d];
      end
   endtask

   task automatic t_reset_state();
      for (int i = 0; i < 4; i++) check_cycle();
      #1 rst = 1'b0;
   endtask

   task automatic t_pattern(input int m, input int n);
      int c0 [2];
      mode = m;
      for (int d = 0; d < 2; d++) c0[d] = caps[d];
      for (int i = 0; i < n; i++) check_cycle();
      for (int d = 0; d < 2; d++)
         chk((caps[d] - c0[d]) >= n / 2 - 2 && (caps[d] - c0[d]) <= n / 2 + 1,
             "R5 capture count", caps[d] - c0[d], n / 2);
   endtask

   task automatic t_mid_reset();
      #1 rst = 1'b1;
      for (int i = 0; i < 3; i++) check_cycle();
      #1 rst = 1'b0;
      for (int i = 0; i < 20; i++) check_cycle();
      for (int d = 0; d < 2; d++)
         chk(last_idx[d] >= 0, "R7 capture resumes", last_idx[d], 0);
   endtask

   initial begin
      #400000;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset_state();
      t_pattern(0, 40);
      t_pattern(1, 40);
      t_pattern(2, 30);
      t_pattern(3, 30);
      t_mid_reset();
      t_pattern(0, 20);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule